// File: doc/BRIEF.md
# Display Controller Run Control and Event Flags

This block holds the run/stop control and the event status of a display controller. Software starts the controller by writing the enable bit with the stop-request bit clear. The controller then waits for the next start-of-frame pulse from the timing generator before it drives `active_o`, which tells the fetch and timing logic to run.

A stop request does not halt the output at once. The controller finishes the frame in flight and drops `active_o` at the next end-of-frame pulse. It then sets a "stopped" status bit, which software polls. Frame and error events are caught in sticky status flags. Each flag has its own interrupt enable, and `irq_o` is the OR of every enabled flag.

The register port has two words, selected by `sel_i`. Writes take effect on the clock edge, and reads are combinational.

Top module: `lcdc_run_ctl`

## Requirements
- R1: After reset the control word and the status word both read 0, and `active_o` and `irq_o` are 0.
- R2: Only control bits 13..7 (interrupt enables), bit 4 (stop request) and bit 3 (enable) can be written. All other control bits read 0.
- R3: While stopped, a control write with bit 3 = 1 and bit 4 = 0 arms the controller. `active_o` stays 0 until a `sof_i` pulse and is 1 in the cycle after that pulse.
- R4: While running, a control word with bit 4 = 1 or bit 3 = 0 keeps `active_o` at 1 through any `sof_i` pulse. `active_o` falls only in the cycle after an `eof_i` pulse, and status bit 0 then reads 1.
- R5: Writing the control word back to bit 3 = 1 with bit 4 = 0 after a completed stop clears status bit 0. The controller then waits for the next `sof_i` before it runs again.
- R6: Sticky flags are set by their events and stay set until cleared. Status bit 4 is set by `sof_i` unless the controller is stopped. Status bit 5 is set by `eof_i` while `active_o` is 1. `evt_i[4:0]` set status bits 7..11 in that order, whatever the run state.
- R7: A status write clears every flag whose bit is written 0 and leaves flags written 1 unchanged. An all-zero write clears all flags. Bit 0 is not affected by status writes.
- R8: When a flag's event and a status write clearing that flag fall in the same cycle, the flag reads 1 afterwards.
- R9: `irq_o` is 1 exactly when some flag is set together with its enable. The enables are control bit 12 for status bit 4, control bit 13 for status bit 5, and control bits 7..11 for status bits 7..11.
- R10: Restoring bit 3 = 1 with bit 4 = 0 while a stop is pending cancels the stop. `active_o` then stays 1 past the next `eof_i`, and status bit 0 stays 0.
- R11: `sof_i` and `eof_i` pulses while the controller is stopped set no flag and do not start it.
- R12: A stop request while armed, before any `sof_i`, stops the controller at once. Status bit 0 reads 1, and a later `sof_i` leaves `active_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Word select: 0 control, 1 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word |
| sof_i | input | 1 | Start-of-frame pulse |
| eof_i | input | 1 | End-of-frame pulse |
| evt_i | input | 5 | Event pulses for status bits 7..11 |
| active_o | output | 1 | Controller running |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can collide in one cycle: a software status write that clears flags, and a hardware event that sets one. The bench provokes this by driving a status write of all zeros in the same cycle as an `eof_i` pulse. It expects the end-of-frame flag to survive while the start-of-frame flag, which has no event that cycle, is cleared. A second collision comes from a cancelled stop: the re-enable reaches the state machine while the drain is still waiting for a frame end. The bench expects `active_o` to stay high across the following `eof_i` and the stopped bit to stay low.

// File: rtl/lcdc_run_pkg.sv
package lcdc_run_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned EVT_N   = 5;
  // control word
  localparam int unsigned C_EN    = 3;
  localparam int unsigned C_STOP  = 4;
  localparam int unsigned C_EVT0  = 7;
  localparam int unsigned C_IESOF = 12;
  localparam int unsigned C_IEEOF = 13;
  // status word
  localparam int unsigned S_OFF   = 0;
  localparam int unsigned S_SOF   = 4;
  localparam int unsigned S_EOF   = 5;
  localparam int unsigned S_EVT0  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } run_state_e;
endpackage

// File: rtl/lcdc_ctrl_reg.sv
module lcdc_ctrl_reg
  import lcdc_run_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o
);
  localparam logic [W-1:0] EVT_BITS = W'(((1 << EVT_N) - 1) << C_EVT0);
  localparam logic [W-1:0] MASK = EVT_BITS | (W'(1) << C_IESOF) | (W'(1) << C_IEEOF)
                                | (W'(1) << C_STOP) | (W'(1) << C_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (wr_i) ctrl_o <= wdata_i & MASK;
  end

  p_ctrl_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o & ~MASK) == '0);
endmodule

// File: rtl/lcdc_run_fsm.sv
module lcdc_run_fsm
  import lcdc_run_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic active_o,
  output logic armed_o,
  output logic off_done_o
);
  run_state_e st_q, st_d;
  logic done_set, done_clr;

  always_comb begin
    st_d     = st_q;
    done_set = 1'b0;
    done_clr = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (go_i) begin st_d = ST_ARMED; done_clr = 1'b1; end
      ST_ARMED: if (!go_i) begin st_d = ST_IDLE; done_set = 1'b1; end
                else if (sof_i) st_d = ST_RUN;
      ST_RUN:   if (!go_i) st_d = ST_DRAIN;
      // withdrawn request wins over a frame end in the same cycle
      ST_DRAIN: if (go_i) st_d = ST_RUN;
                else if (eof_i) begin st_d = ST_IDLE; done_set = 1'b1; end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      off_done_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (done_set)      off_done_o <= 1'b1;
      else if (done_clr) off_done_o <= 1'b0;
    end
  end

  assign active_o = (st_q == ST_RUN) || (st_q == ST_DRAIN);
  assign armed_o  = (st_q != ST_IDLE);

  p_drain_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && !go_i && !eof_i) |=> active_o);
  p_rearm_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED) |-> !off_done_o);
endmodule

// File: rtl/lcdc_flag_bank.sv
module lcdc_flag_bank
  import lcdc_run_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);
  localparam logic [W-1:0] MASK = W'(((1 << EVT_N) - 1) << S_EVT0)
                                | (W'(1) << S_SOF) | (W'(1) << S_EOF);

  logic [W-1:0] keep;
  assign keep = clr_wr_i ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= ((flags_o & keep) | set_i) & MASK;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (MASK[i]) begin : g_flag
      p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o[i] && !(clr_wr_i && !wdata_i[i])) |=> flags_o[i]);
      p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> flags_o[i]);
    end
  end
endmodule

// File: rtl/lcdc_run_ctl.sv
module lcdc_run_ctl
  import lcdc_run_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [EVT_N-1:0] evt_i,
  output logic             active_o,
  output logic             irq_o
);
  logic [REG_W-1:0] ctrl_q, flags_q, set_vec, ie_vec;
  logic go, armed, off_done;

  lcdc_ctrl_reg #(.W(REG_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_i && !sel_i), .wdata_i, .ctrl_o(ctrl_q)
  );

  assign go = ctrl_q[C_EN] && !ctrl_q[C_STOP];

  lcdc_run_fsm u_fsm (
    .clk_i, .rst_ni, .go_i(go), .sof_i, .eof_i,
    .active_o, .armed_o(armed), .off_done_o(off_done)
  );

  always_comb begin
    set_vec = '0;
    set_vec[S_SOF] = sof_i && armed;
    set_vec[S_EOF] = eof_i && active_o;
    set_vec[S_EVT0 +: EVT_N] = evt_i;
    ie_vec = '0;
    ie_vec[S_SOF] = ctrl_q[C_IESOF];
    ie_vec[S_EOF] = ctrl_q[C_IEEOF];
    ie_vec[S_EVT0 +: EVT_N] = ctrl_q[C_EVT0 +: EVT_N];
  end

  lcdc_flag_bank #(.W(REG_W)) u_flags (
    .clk_i, .rst_ni, .clr_wr_i(wr_i && sel_i), .wdata_i,
    .set_i(set_vec), .flags_o(flags_q)
  );

  assign irq_o   = |(flags_q & ie_vec);
  assign rdata_o = sel_i ? (flags_q | (REG_W'(off_done) << S_OFF)) : ctrl_q;

  p_start_at_sof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(sof_i));
  p_stop_at_eof_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(eof_i));
  p_off_not_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_done |-> !active_o);
  p_no_irq_no_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == '0) |-> !irq_o);
endmodule

// File: tb/lcdc_run_ctl_bench.sv
module lcdc_run_ctl_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr = 1'b0, sel = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0] evt = '0;
  logic active, irq;
  int vecs = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcdc_run_ctl u_lcdc_run_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .sel_i(sel), .wdata_i(wdata),
    .rdata_o(rdata), .sof_i(sof), .eof_i(eof), .evt_i(evt),
    .active_o(active), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic wr_reg(logic s, logic [31:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(); @(negedge clk); endtask
  task automatic pulse_sof(); @(negedge clk); sof = 1'b1; @(negedge clk); sof = 1'b0; endtask
  task automatic pulse_eof(); @(negedge clk); eof = 1'b1; @(negedge clk); eof = 1'b0; endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 0);
    rd(1'b1, v); chk("R1 status", v, 0);
    chk("R1 active", active, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] v;
    wr_reg(1'b0, 32'hFFFF_FFFF); idle();
    rd(1'b0, v); chk("R2 ctrl mask", v, 32'h0000_3F98);
    chk("R2 not started", active, 0);
    wr_reg(1'b0, 32'h0); idle();
  endtask

  task automatic t_stopped_pulses();
    logic [31:0] v;
    pulse_sof(); pulse_eof();
    rd(1'b1, v); chk("R11 no flags", v, 0);
    chk("R11 not started", active, 0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr_reg(1'b0, 32'h8); idle(); idle();
    chk("R3 wait sof", active, 0);
    pulse_sof();
    chk("R3 running", active, 1);
    rd(1'b1, v); chk("R6 sof flag", v, 32'h10);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    pulse_eof();
    @(negedge clk); evt = 5'b10101; @(negedge clk); evt = '0;
    idle(); idle();
    rd(1'b1, v); chk("R6 sticky set", v, 32'hAB0);
  endtask

  task automatic t_irq();
    chk("R9 no enable", irq, 0);
    wr_reg(1'b0, 32'h208); chk("R9 evt bit9", irq, 1);
    wr_reg(1'b0, 32'h108); chk("R9 masked bit8", irq, 0);
    wr_reg(1'b0, 32'h1008); chk("R9 sof enable", irq, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr_reg(1'b1, 32'hFFFF_FFDF);
    rd(1'b1, v); chk("R7 clear one", v, 32'hA90);
    wr_reg(1'b1, 32'h0);
    rd(1'b1, v); chk("R7 clear all", v, 0);
    chk("R9 irq drops", irq, 0);
    wr_reg(1'b0, 32'h8);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    pulse_sof();
    @(negedge clk); wr = 1'b1; sel = 1'b1; wdata = 0; eof = 1'b1;
    @(negedge clk); wr = 1'b0; eof = 1'b0;
    rd(1'b1, v); chk("R8 set beats clear", v, 32'h20);
    wr_reg(1'b1, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr_reg(1'b0, 32'h18); idle();
    chk("R4 still running", active, 1);
    pulse_sof();
    chk("R4 runs past sof", active, 1);
    rd(1'b1, v); chk("R4 not yet off", v[0], 0);
    pulse_eof();
    chk("R4 stopped", active, 0);
    rd(1'b1, v); chk("R4 off bit", v[0], 1);
  endtask

  task automatic t_reenable();
    logic [31:0] v;
    wr_reg(1'b0, 32'h8); idle();
    rd(1'b1, v); chk("R5 off cleared", v[0], 0);
    pulse_eof();
    chk("R5 waits sof", active, 0);
    pulse_sof();
    chk("R5 resumed", active, 1);
  endtask

  task automatic t_cancel();
    logic [31:0] v;
    wr_reg(1'b0, 32'h18); idle();
    wr_reg(1'b0, 32'h8); idle();
    pulse_eof();
    chk("R10 keeps running", active, 1);
    rd(1'b1, v); chk("R10 off stays 0", v[0], 0);
  endtask

  task automatic t_armed_abort();
    logic [31:0] v;
    wr_reg(1'b0, 32'h18); idle(); pulse_eof();
    wr_reg(1'b0, 32'h8); idle();
    wr_reg(1'b0, 32'h18); idle();
    rd(1'b1, v); chk("R12 off at once", v[0], 1);
    pulse_sof();
    chk("R12 no start", active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_stopped_pulses();
    t_start();
    t_flags();
    t_irq();
    t_clear();
    t_same_cycle();
    t_disable();
    t_reenable();
    t_cancel();
    t_armed_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule